// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block gathers the event pulses of a small multi-channel DMA engine and turns them into sticky, maskable interrupt state that a host reads and services through a plain 32-bit register port. Five event kinds are tracked for each channel: whole transfer complete, block complete, source transaction, destination transaction and error. Each kind owns four registers with one bit per channel. The first latches the raw events. The second reads as the raw bits gated by the mask. The third is the mask, where a 1 enables the interrupt. The fourth is a write-only register that acknowledges events.

A summary register folds the masked state into one bit per event kind, and a single level-sensitive interrupt line follows it. The block also holds a global controller enable bit and a per-channel enable register. The mask and channel-enable registers take a write-enable byte alongside the data, so software can change one channel without disturbing the others. Host reads are combinational from the address. Writes take effect at the clock edge.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset every raw, mask and channel-enable bit is 0, the controller enable is 0 and `irq` is low.
- R2: A one-cycle pulse on `evt_pulse[k*NUM_CH+n]` (event kind k: 0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 error) sets raw bit n of kind k. The raw register of kind k reads at 0x2C0+8k, bit n, and host writes to it have no effect.
- R3: The status register of kind k at 0x2E8+8k reads as raw AND mask of that kind.
- R4: A write to the mask register of kind k at 0x310+8k changes channel bit n to wdata[n] only when wdata[8+n] is 1. Other bits keep their value, and the register reads back at the same address.
- R5: A write to the clear register of kind k at 0x338+8k clears each raw bit whose wdata bit is 1 and leaves bits written with 0 unchanged. The clear register reads as 0.
- R6: When an event pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R7: The summary register at 0x360 reads with bit k equal to the OR over all channels of the status of kind k, and 0 in bits above 4.
- R8: `irq` is high exactly while some status bit is set, and it is low in the cycle after the write that clears the last one.
- R9: Bit 0 of the register at 0x398 is the controller enable. It drives `ctrl_en` and reads back, and its other bits read as 0.
- R10: The channel-enable register at 0x3A0 follows the same write-enable-byte rule as R4, and its value drives `chan_en`.
- R11: A read of any address not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe for the current address and data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| evt_pulse | input | 5*NUM_CH | Event pulses, bit k*NUM_CH+n for kind k on channel n |
| irq | output | 1 | Level interrupt, any unmasked event pending |
| ctrl_en | output | 1 | Global controller enable |
| chan_en | output | NUM_CH | Per-channel enable |

## Verification
Two actions can land on the same raw bit in one clock edge: a new event from the channel datapath and an acknowledge written by the host. The bench drives both in the same cycle on a bit that is already set. It then reads the raw register back and expects the bit to be 1, because losing that event would be the failure. It also checks that a clear aimed at a different channel bit in the same group leaves the set bit alone. Finally, it checks that `irq` drops one cycle after the last acknowledge and not before.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int NUM_EV     = 5;   // transfer, block, src txn, dst txn, error
   localparam int GRP_STRIDE = 8;   // byte step between event kinds in a family
   localparam int WEN_LSB    = 8;   // first write-enable bit in mask/chan-enable writes
   localparam int WEN_SPAN   = 8;   // number of write-enable bits

   localparam int RAW_BASE  = 'h2C0;
   localparam int STAT_BASE = 'h2E8;
   localparam int CLR_BASE  = 'h338;
   localparam int MASK_BASE = CLR_BASE - NUM_EV * GRP_STRIDE;
   localparam int SUM_ADDR  = 'h360;
   localparam int CFG_ADDR  = 'h398;
   localparam int CHEN_ADDR = 'h3A0;

   typedef enum logic [2:0] {
      RG_NONE, RG_RAW, RG_STAT, RG_MASK, RG_CLR, RG_SUM, RG_CFG, RG_CHEN
   } region_e;

   typedef struct packed {
      region_e    region;
      logic [2:0] grp;
   } dec_t;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
   import dma_irq_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   always_comb begin
      dec = '{region: RG_NONE, grp: '0};
      for (int e = 0; e < NUM_EV; e++) begin
         if (addr == ADDR_W'(RAW_BASE + e * GRP_STRIDE)) begin
            dec.region = RG_RAW;  dec.grp = 3'(e);
         end
         if (addr == ADDR_W'(STAT_BASE + e * GRP_STRIDE)) begin
            dec.region = RG_STAT; dec.grp = 3'(e);
         end
         if (addr == ADDR_W'(MASK_BASE + e * GRP_STRIDE)) begin
            dec.region = RG_MASK; dec.grp = 3'(e);
         end
         if (addr == ADDR_W'(CLR_BASE + e * GRP_STRIDE)) begin
            dec.region = RG_CLR;  dec.grp = 3'(e);
         end
      end
      if (addr == ADDR_W'(SUM_ADDR))  dec.region = RG_SUM;
      if (addr == ADDR_W'(CFG_ADDR))  dec.region = RG_CFG;
      if (addr == ADDR_W'(CHEN_ADDR)) dec.region = RG_CHEN;
   end
endmodule

// File: rtl/dma_irq_wen_reg.sv
module dma_irq_wen_reg #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] val,
   input  logic [W-1:0] en,
   output logic [W-1:0] q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (we && en[b])
            bit_q <= val[b];
      end
      assign q[b] = bit_q;
   end
endmodule

// File: rtl/dma_irq_group.sv
module dma_irq_group #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt,
   input  logic              clr_we,
   input  logic [NUM_CH-1:0] clr_bits,
   input  logic              mask_we,
   input  logic [NUM_CH-1:0] mask_val,
   input  logic [NUM_CH-1:0] mask_en,
   output logic [NUM_CH-1:0] raw,
   output logic [NUM_CH-1:0] mask,
   output logic [NUM_CH-1:0] stat
);
   logic [NUM_CH-1:0] raw_q;
   logic [NUM_CH-1:0] ack;

   assign ack = clr_we ? clr_bits : '0;

   // a fresh event is OR-ed in after the acknowledge, so it survives a collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         raw_q <= '0;
      else
         raw_q <= (raw_q & ~ack) | evt;
   end

   dma_irq_wen_reg #(.W(NUM_CH)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we),
      .val   (mask_val),
      .en    (mask_en),
      .q     (mask)
   );

   assign raw  = raw_q;
   assign stat = raw_q & mask;
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic                     reg_wr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   input  logic [NUM_EV*NUM_CH-1:0] evt_pulse,
   output logic                     irq,
   output logic                     ctrl_en,
   output logic [NUM_CH-1:0]        chan_en
);
   localparam int FLAT_W = NUM_EV * NUM_CH;

   if (NUM_CH < 1 || NUM_CH > WEN_SPAN) begin : g_bad_ch
      $error("dma_irq_bank: NUM_CH must be 1..%0d", WEN_SPAN);
   end
   if (DATA_W < WEN_LSB + WEN_SPAN) begin : g_bad_dw
      $error("dma_irq_bank: DATA_W too narrow for the write-enable byte");
   end
   if (ADDR_W < 10) begin : g_bad_aw
      $error("dma_irq_bank: ADDR_W must reach the top register");
   end

   dec_t dec;

   dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (reg_addr),
      .dec  (dec)
   );

   logic [NUM_CH-1:0] wr_val;
   logic [NUM_CH-1:0] wr_en;
   assign wr_val = reg_wdata[NUM_CH-1:0];
   assign wr_en  = reg_wdata[WEN_LSB +: NUM_CH];

   logic [NUM_EV-1:0][NUM_CH-1:0] raw_v, mask_v, stat_v;
   logic [NUM_EV-1:0]             summary;

   for (genvar e = 0; e < NUM_EV; e++) begin : g_grp
      logic hit_clr, hit_mask;
      assign hit_clr  = reg_wr && dec.region == RG_CLR  && dec.grp == 3'(e);
      assign hit_mask = reg_wr && dec.region == RG_MASK && dec.grp == 3'(e);

      dma_irq_group #(.NUM_CH(NUM_CH)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_pulse[e*NUM_CH +: NUM_CH]),
         .clr_we   (hit_clr),
         .clr_bits (wr_val),
         .mask_we  (hit_mask),
         .mask_val (wr_val),
         .mask_en  (wr_en),
         .raw      (raw_v[e]),
         .mask     (mask_v[e]),
         .stat     (stat_v[e])
      );

      assign summary[e] = |stat_v[e];
   end

   assign irq = |summary;

   // channel enables share the write-enable-byte cell with the masks
   dma_irq_wen_reg #(.W(NUM_CH)) u_chen (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_wr && dec.region == RG_CHEN),
      .val   (wr_val),
      .en    (wr_en),
      .q     (chan_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_en <= 1'b0;
      else if (reg_wr && dec.region == RG_CFG)
         ctrl_en <= reg_wdata[0];
   end

   always_comb begin
      reg_rdata = '0;
      unique case (dec.region)
         RG_RAW:  reg_rdata[NUM_CH-1:0] = raw_v[dec.grp];
         RG_STAT: reg_rdata[NUM_CH-1:0] = stat_v[dec.grp];
         RG_MASK: reg_rdata[NUM_CH-1:0] = mask_v[dec.grp];
         RG_SUM:  reg_rdata[NUM_EV-1:0] = summary;
         RG_CFG:  reg_rdata[0]          = ctrl_en;
         RG_CHEN: reg_rdata[NUM_CH-1:0] = chan_en;
         default: reg_rdata = '0;
      endcase
   end

   // flat views for the bound checker
   logic [FLAT_W-1:0] raw_flat, mask_flat;
   assign raw_flat  = raw_v;
   assign mask_flat = mask_v;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     reg_wr,
   input logic [NUM_EV*NUM_CH-1:0] evt_pulse,
   input logic [NUM_EV*NUM_CH-1:0] raw_flat,
   input logic [NUM_EV*NUM_CH-1:0] mask_flat,
   input logic                     irq,
   input logic                     ctrl_en,
   input logic [NUM_CH-1:0]        chan_en
);
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (raw_flat == '0 && mask_flat == '0 && !ctrl_en && chan_en == '0 && !irq));

   // R2 and R6: every pulse is visible in raw one edge later, clear or not
   a_r6_event_never_lost: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((raw_flat & $past(evt_pulse)) == $past(evt_pulse)));

   a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((raw_flat & ~$past(raw_flat) & ~$past(evt_pulse)) == '0));

   a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(reg_wr)) |-> ((~raw_flat & $past(raw_flat)) == '0));

   a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(reg_wr)) |-> $stable(mask_flat));

   a_r9_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(reg_wr)) |-> $stable(ctrl_en));

   a_r10_chen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(reg_wr)) |-> $stable(chan_en));

   a_r8_irq_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw_flat & mask_flat)) |-> irq);

   a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw_flat & mask_flat)) |-> !irq);
endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .evt_pulse (evt_pulse),
   .raw_flat  (raw_flat),
   .mask_flat (mask_flat),
   .irq       (irq),
   .ctrl_en   (ctrl_en),
   .chan_en   (chan_en)
);

// File: tb/test_dma_irq_bank.sv
module test_dma_irq_bank;
   localparam int NCH = 2;
   localparam int NEV = 5;
   localparam int K_RD = 0, K_IRQ = 1, K_CEN = 2, K_CHEN = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [11:0]       reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [NEV*NCH-1:0] evt_pulse = '0;
   logic              irq, ctrl_en;
   logic [NCH-1:0]    chan_en;

   always #2 clk = ~clk;   // 250 MHz

   dma_irq_bank #(.NUM_CH(NCH)) i_dma_irq_bank (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
      .irq(irq), .ctrl_en(ctrl_en), .chan_en(chan_en)
   );

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int nchecks = 0;
   int nfail = 0;
   bit done = 0;

   function automatic int raw_a(int k);  return 'h2C0 + 8*k; endfunction
   function automatic int stat_a(int k); return 'h2E8 + 8*k; endfunction
   function automatic int mask_a(int k); return 'h310 + 8*k; endfunction
   function automatic int clr_a(int k);  return 'h338 + 8*k; endfunction
   function automatic logic [NEV*NCH-1:0] ev(int k, int ch);
      ev = '0; ev[k*NCH+ch] = 1'b1;
   endfunction

   // monitor: compare each queued expectation just after the edge
   initial begin
      forever begin
         @(posedge clk); #1;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               K_IRQ:   act = {31'b0, irq};
               K_CEN:   act = {31'b0, ctrl_en};
               K_CHEN:  act = 32'(chan_en);
               default: act = reg_rdata;
            endcase
            nchecks++;
            if (act !== it.exp) begin
               nfail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = 12'(a); reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_exp(input int a, input logic [31:0] e, input string tag);
      @(negedge clk);
      reg_addr = 12'(a);
      q.push_back('{K_RD, e, tag});
      @(posedge clk);
   endtask

   task automatic out_exp(input int kind, input logic [31:0] e, input string tag);
      @(negedge clk);
      q.push_back('{kind, e, tag});
      @(posedge clk);
   endtask

   task automatic pulse(input logic [NEV*NCH-1:0] v);
      @(negedge clk);
      evt_pulse = v;
      @(posedge clk); #1;
      evt_pulse = '0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < NEV; k++) begin
         rd_exp(raw_a(k), 0, "R1 raw reset");
         rd_exp(mask_a(k), 0, "R1 mask reset");
      end
      rd_exp('h3A0, 0, "R1 chan enable reset");
      out_exp(K_IRQ, 0, "R1 irq reset");
      out_exp(K_CEN, 0, "R1 ctrl_en reset");

      // R2 each kind on its own channel bit
      for (int k = 0; k < NEV; k++) begin
         pulse(ev(k, k % NCH));
         rd_exp(raw_a(k), 32'(1 << (k % NCH)), "R2 raw set by event");
         wr(clr_a(k), 32'h3);
         rd_exp(raw_a(k), 0, "R5 raw cleared");
      end

      pulse(ev(0, 1) | ev(4, 0));
      rd_exp(raw_a(0), 2, "R2 raw transfer ch1");
      rd_exp(raw_a(4), 1, "R2 raw error ch0");
      rd_exp(stat_a(0), 0, "R3 status masked off");
      rd_exp('h360, 0, "R7 summary all masked");
      out_exp(K_IRQ, 0, "R8 irq masked");

      // R2 raw is read-only
      wr(raw_a(0), 32'h0);
      rd_exp(raw_a(0), 2, "R2 raw ignores write");

      // R4 write-enable byte
      wr(mask_a(0), 32'h0302);
      rd_exp(mask_a(0), 2, "R4 mask enabled bits");
      rd_exp(stat_a(0), 2, "R3 status raw and mask");
      rd_exp('h360, 1, "R7 summary transfer bit");
      out_exp(K_IRQ, 1, "R8 irq pending");
      wr(mask_a(0), 32'h0001);
      rd_exp(mask_a(0), 2, "R4 mask without enable unchanged");
      wr(mask_a(0), 32'h0101);
      rd_exp(mask_a(0), 3, "R4 mask ch0 only");

      // R5 clear of an unset bit, clear reads zero
      wr(clr_a(0), 32'h1);
      rd_exp(raw_a(0), 2, "R5 clear other bit keeps raw");
      rd_exp(clr_a(0), 0, "R5 clear reads zero");

      // R6 event and clear collide on the same bit
      @(negedge clk);
      reg_addr = 12'(clr_a(0)); reg_wdata = 32'h2; reg_wr = 1'b1;
      evt_pulse = ev(0, 1);
      @(posedge clk); #1;
      reg_wr = 1'b0; evt_pulse = '0;
      rd_exp(raw_a(0), 2, "R6 event wins over clear");
      out_exp(K_IRQ, 1, "R8 irq still pending");

      // R8 irq drops one cycle after the last clear
      wr(clr_a(0), 32'h2);
      out_exp(K_IRQ, 0, "R8 irq drops after clear");
      rd_exp('h360, 0, "R7 summary cleared");

      wr(mask_a(4), 32'h0101);
      rd_exp(stat_a(4), 1, "R3 status error");
      rd_exp('h360, 32'h10, "R7 summary error bit");
      out_exp(K_IRQ, 1, "R8 irq error");
      wr(clr_a(4), 32'h1);
      out_exp(K_IRQ, 0, "R8 irq error cleared");

      // R9 controller enable
      wr('h398, 32'hFFFF_FFFF);
      rd_exp('h398, 1, "R9 cfg reads bit0");
      out_exp(K_CEN, 1, "R9 ctrl_en high");
      wr('h398, 32'h0);
      out_exp(K_CEN, 0, "R9 ctrl_en low");

      // R10 channel enable
      wr('h3A0, 32'h0303);
      rd_exp('h3A0, 3, "R10 chan enable set");
      out_exp(K_CHEN, 3, "R10 chan_en out");
      wr('h3A0, 32'h0200);
      rd_exp('h3A0, 1, "R10 chan enable partial");
      out_exp(K_CHEN, 1, "R10 chan_en partial");

      // R11 unmapped addresses
      pulse(ev(0, 0));
      rd_exp('h2C4, 0, "R11 gap in raw family");
      rd_exp('h004, 0, "R11 low address");
      rd_exp('h3FC, 0, "R11 top address");

      @(negedge clk);
      @(posedge clk); #2;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
   end
endmodule